// File: doc/BRIEF.md
# Line First-Word Extractor

This block filters a byte stream so that only the first word of every text line gets through. It takes one byte per cycle, qualified by a valid strobe. Each byte is sorted into one of three classes: space, newline or other. A three-state controller then decides whether to forward the byte. The three states are: before the word, inside the word, and past the word.

Leading spaces are removed. The characters of the first word are passed on. Everything after the space that ends the word is dropped. The newline is always forwarded, and it returns the controller to the start of the next line. The forwarded bytes leave through a registered output with its own valid strobe, one cycle after they arrive. Parameters set the byte codes of space and newline. Two further parameters decide whether tab and carriage return also count as space.

Top module: `lfw_first_word`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters the before-word state and `out_valid` is low in the following cycle.
- R2: A newline byte (0x0A by default) is forwarded in every state, and the line restarts in the before-word state.
- R3: Before the word, a space byte (0x20 by default) is dropped and the state is kept; any other non-newline byte is forwarded and the word begins.
- R4: Inside the word, a space byte is dropped and ends the word; any other non-newline byte is forwarded and the state is kept.
- R5: After the word has ended, every non-newline byte is dropped until a newline arrives.
- R6: A forwarded byte appears on `out_data` with `out_valid` high in the cycle right after the edge that sampled it.
- R7: A cycle with `in_valid` low emits nothing and leaves the state unchanged, so the line resumes where it stopped.
- R8: Tab (0x09) and carriage return (0x0D) belong to the other class by default. Setting `TAB_IS_SPACE` or `CR_IS_SPACE` to 1 moves the matching byte into the space class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | DATA_W | Incoming byte |
| out_valid | output | 1 | High for one cycle per forwarded byte |
| out_data | output | DATA_W | Forwarded byte |

## Verification
The bench builds two instances side by side and feeds both the same stream. The first instance keeps the defaults, so tab and carriage return belong to the other class. The second sets `TAB_IS_SPACE` and `CR_IS_SPACE` to 1. As a result, the same tab or carriage return byte is forwarded by one instance and dropped, or made to end the word, by the other. The stream also covers leading spaces, empty lines, multiple words and idle gaps inside a word. These exercise every state-class pair on both variants.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

    typedef enum logic [1:0] {
        LFW_START = 2'd0,
        LFW_WORD  = 2'd1,
        LFW_PAST  = 2'd2
    } lfw_state_e;

    typedef enum logic [1:0] {
        CLS_SPACE   = 2'd0,
        CLS_NEWLINE = 2'd1,
        CLS_OTHER   = 2'd2
    } lfw_class_e;

    localparam int unsigned LFW_NUM_STATES  = 3;
    localparam int unsigned LFW_NUM_CLASSES = 3;
    localparam int unsigned LFW_TABLE_SIZE  = LFW_NUM_STATES * LFW_NUM_CLASSES;

    typedef struct packed {
        lfw_state_e next;
        logic       keep;
    } lfw_step_t;

    // Transition rule for one (state, class) pair.
    function automatic lfw_step_t lfw_step(lfw_state_e st, lfw_class_e cl);
        lfw_step_t r;
        r.next = st;
        r.keep = 1'b0;
        if (cl == CLS_NEWLINE) begin
            r.next = LFW_START;
            r.keep = 1'b1;
        end else begin
            case (st)
                LFW_START: begin
                    if (cl == CLS_OTHER) begin
                        r.next = LFW_WORD;
                        r.keep = 1'b1;
                    end
                end
                LFW_WORD: begin
                    if (cl == CLS_SPACE) r.next = LFW_PAST;
                    else                 r.keep = 1'b1;
                end
                default: begin
                    r.next = LFW_PAST;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lfw_classify.sv
module lfw_classify
    import lfw_pkg::*;
#(
    parameter int unsigned    DATA_W       = 8,
    parameter logic [DATA_W-1:0] SPACE_CODE   = 8'h20,
    parameter logic [DATA_W-1:0] NEWLINE_CODE = 8'h0A,
    parameter logic [DATA_W-1:0] TAB_CODE     = 8'h09,
    parameter logic [DATA_W-1:0] CR_CODE      = 8'h0D,
    parameter bit             TAB_IS_SPACE = 1'b0,
    parameter bit             CR_IS_SPACE  = 1'b0
) (
    input  logic [DATA_W-1:0] sym,
    output lfw_class_e        cls
);
    logic hit_space;
    logic hit_tab;
    logic hit_cr;
    logic hit_nl;

    assign hit_space = (sym == SPACE_CODE);
    assign hit_nl    = (sym == NEWLINE_CODE);

    generate
        if (TAB_IS_SPACE) begin : g_tab_sp
            assign hit_tab = (sym == TAB_CODE);
        end else begin : g_tab_other
            assign hit_tab = 1'b0;
        end
        if (CR_IS_SPACE) begin : g_cr_sp
            assign hit_cr = (sym == CR_CODE);
        end else begin : g_cr_other
            assign hit_cr = 1'b0;
        end
    endgenerate

    always_comb begin
        if (hit_nl)                           cls = CLS_NEWLINE;
        else if (hit_space | hit_tab | hit_cr) cls = CLS_SPACE;
        else                                  cls = CLS_OTHER;
    end
endmodule

// File: rtl/lfw_step_table.sv
module lfw_step_table
    import lfw_pkg::*;
(
    input  lfw_state_e cur,
    input  lfw_class_e cls,
    output lfw_step_t  step
);
    localparam int unsigned IDX_W = $clog2(LFW_TABLE_SIZE);

    lfw_step_t table_q [LFW_TABLE_SIZE];

    generate
        for (genvar s = 0; s < LFW_NUM_STATES; s++) begin : g_st
            for (genvar c = 0; c < LFW_NUM_CLASSES; c++) begin : g_cl
                assign table_q[s*LFW_NUM_CLASSES + c] =
                    lfw_step(lfw_state_e'(s), lfw_class_e'(c));
            end
        end
    endgenerate

    logic [IDX_W-1:0] idx;
    logic             legal;

    assign legal = (cur != 2'd3) && (cls != 2'd3);
    assign idx   = IDX_W'(cur) * IDX_W'(LFW_NUM_CLASSES) + IDX_W'(cls);

    always_comb begin
        if (legal) begin
            step = table_q[idx];
        end else begin
            step.next = LFW_START;
            step.keep = 1'b0;
        end
    end
endmodule

// File: rtl/lfw_emit_reg.sv
module lfw_emit_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] sym,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_data <= sym;
        end
    end

    // R6
    emit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_valid && out_data == $past(sym)));
endmodule

// File: rtl/lfw_first_word.sv
module lfw_first_word
    import lfw_pkg::*;
#(
    parameter int unsigned    DATA_W       = 8,
    parameter logic [DATA_W-1:0] SPACE_CODE   = 8'h20,
    parameter logic [DATA_W-1:0] NEWLINE_CODE = 8'h0A,
    parameter bit             TAB_IS_SPACE = 1'b0,
    parameter bit             CR_IS_SPACE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    lfw_state_e state_q;
    lfw_class_e cls;
    lfw_step_t  step;
    logic       fire;

    lfw_classify #(
        .DATA_W      (DATA_W),
        .SPACE_CODE  (SPACE_CODE),
        .NEWLINE_CODE(NEWLINE_CODE),
        .TAB_CODE    (DATA_W'(8'h09)),
        .CR_CODE     (DATA_W'(8'h0D)),
        .TAB_IS_SPACE(TAB_IS_SPACE),
        .CR_IS_SPACE (CR_IS_SPACE)
    ) u_classify (
        .sym(in_data),
        .cls(cls)
    );

    lfw_step_table u_table (
        .cur (state_q),
        .cls (cls),
        .step(step)
    );

    assign fire = in_valid & step.keep;

    always_ff @(posedge clk) begin
        if (rst)           state_q <= LFW_START;
        else if (in_valid) state_q <= step.next;
    end

    lfw_emit_reg #(.DATA_W(DATA_W)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .sym      (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    // R1
    reset_start_chk: assert property (@(posedge clk)
        rst |=> (state_q == LFW_START && !out_valid));

    // R2
    newline_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_NEWLINE) |=> (out_valid && state_q == LFW_START));

    // R3
    lead_space_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == LFW_START && cls == CLS_SPACE) |=>
        (!out_valid && state_q == LFW_START));

    // R4
    word_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == LFW_WORD && cls == CLS_SPACE) |=>
        (!out_valid && state_q == LFW_PAST));

    // R5
    past_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == LFW_PAST && cls != CLS_NEWLINE) |=>
        (!out_valid && state_q == LFW_PAST));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(state_q)));
endmodule

// File: tb/test_lfw_first_word.sv
module test_lfw_first_word;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       va, vb;
    logic [7:0] da, db;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lfw_first_word i_lfw_first_word (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(va), .out_data(da)
    );

    lfw_first_word #(.TAB_IS_SPACE(1'b1), .CR_IS_SPACE(1'b1)) i_lfw_first_word_sp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(vb), .out_data(db)
    );

    // Scoreboard queues, one set per instance (0: defaults, 1: tab/cr as space)
    logic [7:0] exp_d0[$], exp_d1[$];
    int         exp_c0[$], exp_c1[$];
    string      exp_t0[$], exp_t1[$];
    bit         got_char[2];
    bit         closed[2];

    function automatic bit is_sp(int m, logic [7:0] b);
        return (b == 8'h20) || (m == 1 && (b == 8'h09 || b == 8'h0D));
    endfunction

    task automatic model(int m, logic [7:0] b, int at);
        bit    keep;
        string tag;
        keep = 1'b0;
        tag  = "R3";
        if (b == 8'h0A) begin
            keep = 1'b1; tag = "R2";
            got_char[m] = 1'b0; closed[m] = 1'b0;
        end else if (closed[m]) begin
            keep = 1'b0;
        end else if (is_sp(m, b)) begin
            if (got_char[m]) closed[m] = 1'b1;
        end else begin
            keep = 1'b1;
            tag  = got_char[m] ? "R4" : "R3";
            got_char[m] = 1'b1;
        end
        if (b == 8'h09 || b == 8'h0D) tag = "R8";
        if (keep) begin
            if (m == 0) begin exp_d0.push_back(b); exp_c0.push_back(at); exp_t0.push_back(tag); end
            else        begin exp_d1.push_back(b); exp_c1.push_back(at); exp_t1.push_back(tag); end
        end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        model(0, b, cyc + 1);
        model(1, b, cyc + 1);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 8'hAA;
        end
    endtask

    task automatic send_str(string s);
        for (int k = 0; k < s.len(); k++) send(s[k]);
    endtask

    task automatic check_port(int m, logic v, logic [7:0] d);
        logic [7:0] ed;
        int         ec;
        string      et;
        if (!v) return;
        compared++;
        if ((m == 0 && exp_d0.size() == 0) || (m == 1 && exp_d1.size() == 0)) begin
            mismatched++;
            $display("FAIL inst%0d R5/R7 unexpected output: actual %h expected none", m, d);
            return;
        end
        if (m == 0) begin ed = exp_d0.pop_front(); ec = exp_c0.pop_front(); et = exp_t0.pop_front(); end
        else        begin ed = exp_d1.pop_front(); ec = exp_c1.pop_front(); et = exp_t1.pop_front(); end
        if (d !== ed) begin
            mismatched++;
            $display("FAIL inst%0d %s data: actual %h expected %h", m, et, d, ed);
        end
        compared++;
        if (cyc != ec) begin
            mismatched++;
            $display("FAIL inst%0d R6 latency of %h: actual cycle %0d expected %0d", m, ed, cyc, ec);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            check_port(0, va, da);
            check_port(1, vb, db);
        end
    end

    // Watchdog
    initial begin
        #100000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        got_char[0] = 0; got_char[1] = 0; closed[0] = 0; closed[1] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the outputs
        compared++;
        if (va !== 1'b0 || vb !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 out_valid after reset: actual %b%b expected 00", va, vb);
        end
        rst = 1'b0;
        send_str("  hello world\n");   // R3 leading space, R4 word end, R5 drop
        send_str("abc\n");
        send_str("\n");                // R2 empty line
        send_str("x y z\n");
        send_str("he");                // R7 gap inside the word
        idle(3);
        send_str("y there\n");
        send_str("   ");               // R7 gap before the word
        idle(2);
        send_str("q  r\n");
        send_str("\tab c\n");          // R8 tab
        send_str("ab\tcd ef\n");       // R8 tab inside word
        send_str("ab\015\n");          // R8 carriage return
        send_str("cd\015ef gh\n");
        send_str("one two");
        idle(2);
        send_str("three\n");
        idle(4);
        // Every expected item must have been seen
        compared++;
        if (exp_d0.size() != 0 || exp_d1.size() != 0) begin
            mismatched++;
            $display("FAIL R2/R3/R4 missing outputs: actual %0d/%0d left expected 0/0",
                     exp_d0.size(), exp_d1.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule